// File: doc/BRIEF.md
# I2C Register-File Target

This block is an I2C target that gives a controller access to a bank of 25 byte-wide registers at addresses 0x00 to 0x18. It oversamples SCL and SDA with the system clock, finds START, repeated START and STOP, and answers at one of two 7-bit addresses picked by a select input. A write transaction carries a register pointer byte and then data bytes. A read transaction streams register contents from the current pointer. The pointer steps after every byte and wraps from the last register back to the first.

The register storage sits outside the block. Each accepted data byte appears as a one-clock write strobe with its address and data. Each byte to be sent is fetched through a read request: the block presents an address and samples the returned data in the same clock. SDA is open-drain, so the block only drives a pull-low enable. A START or STOP that cuts a byte short throws that byte away.

Top module: `i2c_regfile_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits are 0x0A when `addr_sel` is 0, or 0x0D when `addr_sel` is 1. Bit 0 of that byte is 1 for a read and 0 for a write. For any other address it never pulls SDA low, and that transaction has no further effect.
- R2: SDA is sampled on SCL rising edges. A falling SDA while SCL is high is a START, and a rising SDA while SCL is high is a STOP. The target pulls SDA low through the ninth clock of every byte it accepts, and it changes `sda_oe` only while SCL is low.
- R3: In a write, the first byte after the address sets the pointer from its low five bits. A value above 0x18 sets the pointer to 0x00.
- R4: Each later data byte of a write produces one single-clock `wr_en` pulse, with `wr_addr` equal to the pointer and `wr_data` equal to the byte. The pulse comes while SCL is low, ahead of the acknowledge clock. The pointer then steps by one.
- R5: Whenever the pointer steps past 0x18, it becomes 0x00. This holds for both reads and writes.
- R6: Data bytes aimed at 0x13 to 0x18 are acknowledged and step the pointer, but they give no `wr_en`.
- R7: A read sends the byte at the pointer, MSB first. The block requests it through `rd_req` and `rd_addr`, then steps the pointer.
- R8: A read with no pointer byte before it starts at the address after the last register written or read.
- R9: A write with only a pointer byte, followed by a repeated START and a read address, returns data starting at that pointer.
- R10: If the controller NACKs a read byte, the target releases SDA and drives nothing more until the next START.
- R11: A START or STOP in the middle of a pointer byte or a data byte discards that byte. No strobe is given and the pointer keeps its value.
- R12: After reset, `sda_oe`, `wr_en` and `rd_req` are low and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 1 | Chooses which of the two target addresses is answered |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| wr_en | output | 1 | One-clock register write strobe |
| wr_addr | output | 5 | Register address for the write |
| wr_data | output | 8 | Register data for the write |
| rd_req | output | 1 | One-clock read request |
| rd_addr | output | 5 | Register address being read |
| rd_data | input | 8 | Register contents for `rd_addr`, valid in the same clock |

## Verification
The transactions cover several cases. Plain writes show that strobes carry the right address and data. A write that starts at 0x17 shows both the read-only skip and the wrap, because only the byte that lands on 0x00 gives a strobe. Reads with no pointer byte, and reads after a repeated START, check that the pointer is carried between transactions. Bytes cut short by a START or STOP check that neither the strobe nor the pointer changes. Wrong addresses and a pointer above 0x18 exercise the rejection and clamping paths.

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
  parameter int          NREG    = 25,
  parameter int          RO_BASE = 19,
  parameter int          AW      = 5,
  parameter int          DW      = 8,
  parameter logic [6:0]  ID_LO   = 7'h0A,
  parameter logic [6:0]  ID_HI   = 7'h0D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_sel,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data
);
  localparam int LAST = NREG - 1;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_PTR, S_WR, S_RD, S_HOLD} state_t;

  state_t        state;
  logic [2:0]    scl_q, sda_q;
  logic [3:0]    cnt;
  logic [DW-1:0] shreg, tx;
  logic [AW-1:0] ptr, ptr_nxt;
  logic          nack;

  wire scl_s   = scl_q[1];
  wire scl_p   = scl_q[2];
  wire sda_s   = sda_q[1];
  wire start_c = scl_s & scl_p & sda_q[2] & ~sda_s;
  wire stop_c  = scl_s & scl_p & ~sda_q[2] & sda_s;
  wire rise    = scl_s & ~scl_p;
  wire fall    = ~scl_s & scl_p;
  wire hit     = shreg[7:1] == (addr_sel ? ID_HI : ID_LO);
  wire byte_end = fall && cnt == 4'd9;

  assign ptr_nxt = (ptr == AW'(LAST)) ? '0 : ptr + 1'b1;
  assign rd_addr = ptr;
  assign rd_req  = byte_end && ((state == S_ADDR && hit && shreg[0]) ||
                                (state == S_RD && !nack));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q   <= '1;
      sda_q   <= '1;
      state   <= S_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      tx      <= '0;
      ptr     <= '0;
      nack    <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
      wr_en <= 1'b0;
      if (start_c) begin
        state  <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (state != S_IDLE) begin
        if (rise) begin
          cnt <= cnt + 1'b1;
          if (cnt < 4'd8) shreg <= {shreg[DW-2:0], sda_s};
          else            nack  <= sda_s;
        end
        if (fall) begin
          if (cnt == 4'd8) begin
            case (state)
              S_ADDR: sda_oe <= hit;
              S_PTR: begin
                sda_oe <= 1'b1;
                ptr    <= (shreg[AW-1:0] > AW'(LAST)) ? '0 : shreg[AW-1:0];
              end
              S_WR: begin
                sda_oe  <= 1'b1;
                wr_en   <= ptr < AW'(RO_BASE);
                wr_addr <= ptr;
                wr_data <= shreg;
                ptr     <= ptr_nxt;
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (cnt == 4'd9) begin
            cnt    <= '0;
            sda_oe <= 1'b0;
            case (state)
              S_ADDR:  state <= !hit ? S_HOLD : (shreg[0] ? S_RD : S_PTR);
              S_PTR:   state <= S_WR;
              S_RD:    if (nack) state <= S_HOLD;
              default: ;
            endcase
            if (rd_req) begin
              sda_oe <= ~rd_data[DW-1];
              tx     <= {rd_data[DW-2:0], 1'b0};
              ptr    <= ptr_nxt;
            end
          end else if (state == S_RD && cnt != 4'd0) begin
            sda_oe <= ~tx[DW-1];
            tx     <= {tx[DW-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_regfile_target_chk.sv
module i2c_regfile_target_chk #(
  parameter int NREG    = 25,
  parameter int RO_BASE = 19,
  parameter int AW      = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_in,
  input logic          sda_oe,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr
);
  assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  assert_wr_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !scl_in);
  assert_ro_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_addr < AW'(RO_BASE));
  assert_rd_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr <= AW'(NREG - 1));
  assert_oe_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_in);
endmodule

bind i2c_regfile_target i2c_regfile_target_chk #(.NREG(NREG), .RO_BASE(RO_BASE), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe), .wr_en(wr_en),
  .wr_addr(wr_addr), .rd_req(rd_req), .rd_addr(rd_addr)
);

// File: tb/test_i2c_regfile_target.sv
module test_i2c_regfile_target;
  localparam int Q = 10;
  logic clk = 1'b0, rst_n = 1'b0, addr_sel = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, wr_en, rd_req;
  logic [4:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [7:0] mem [0:24];
  wire  sda_line = sda_m & ~sda_oe;
  int   checks = 0, fails = 0, wcount = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  i2c_regfile_target i_i2c_regfile_target (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_in(scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data));

  assign rd_data = mem[rd_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 25; i++) mem[i] = 8'hA0 + 8'(i);
    end else if (wr_en) begin
      mem[wr_addr] = wr_data;
      wcount++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic w(); repeat (Q) @(negedge clk); endtask
  task automatic start(); sda_m = 1; w(); scl = 1; w(); sda_m = 0; w(); scl = 0; w(); endtask
  task automatic stop(); sda_m = 0; w(); scl = 1; w(); sda_m = 1; w(); endtask
  task automatic wbit(input bit b); sda_m = b; w(); scl = 1; w(); w(); scl = 0; w(); endtask
  task automatic rbit(output bit b); sda_m = 1; w(); scl = 1; w(); b = sda_line; w(); scl = 0; w(); endtask

  task automatic send(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = !b;
  endtask

  task automatic recv(input bit last, output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
    wbit(last);
  endtask

  task automatic t_reset();
    chk(sda_oe == 0 && wr_en == 0 && rd_req == 0, "R12 outputs", {sda_oe, wr_en, rd_req}, 0);
  endtask

  task automatic t_first_read();
    bit a; logic [7:0] d;
    start(); send({7'h0A, 1'b1}, a);
    chk(a, "R1 ack addr 0x0A sel0", a, 1);
    recv(1, d); stop();
    chk(d == 8'hA0, "R12 pointer starts at 0", d, 8'hA0);
  endtask

  task automatic t_addr_select();
    bit a;
    start(); send({7'h10, 1'b0}, a); stop();
    chk(!a, "R1 foreign address ignored", a, 0);
    addr_sel = 1;
    start(); send({7'h0A, 1'b0}, a); stop();
    chk(!a, "R1 0x0A ignored with sel1", a, 0);
    start(); send({7'h0D, 1'b0}, a); stop();
    chk(a, "R1 0x0D acked with sel1", a, 1);
    addr_sel = 0;
    chk(wcount == 0, "R1 no strobes", wcount, 0);
  endtask

  task automatic t_write();
    bit a0, a1, a2, a3;
    start(); send({7'h0A, 1'b0}, a0); send(8'h03, a1); send(8'h11, a2); send(8'h22, a3); stop();
    chk(a0 && a1 && a2 && a3, "R2 every byte acked", {a0, a1, a2, a3}, 4'hF);
    chk(wcount == 2, "R4 strobe count", wcount, 2);
    chk(mem[3] == 8'h11 && mem[4] == 8'h22, "R4 written data", {mem[3], mem[4]}, 16'h1122);
  endtask

  task automatic t_ro_wrap();
    bit a0, a1, a2, a3, a4;
    int c0 = wcount;
    start(); send({7'h0A, 1'b0}, a0); send(8'h17, a1); send(8'h55, a2);
    chk(wcount == c0 && a2, "R6 read-only byte skipped but acked", wcount - c0, 0);
    send(8'h77, a3); send(8'h66, a4); stop();
    chk(wcount == c0 + 1, "R6 only one strobe", wcount - c0, 1);
    chk(mem[0] == 8'h66, "R5 write wraps to 0x00", mem[0], 8'h66);
  endtask

  task automatic t_resume_nack();
    bit a, b; logic [7:0] d1, d2;
    start(); send({7'h0A, 1'b1}, a); recv(0, d1); recv(1, d2);
    chk(d1 == 8'hA1, "R8 read resumes after last access", d1, 8'hA1);
    chk(d2 == 8'hA2, "R7 read auto-increment", d2, 8'hA2);
    rbit(b); rbit(b);
    chk(b == 1 && sda_oe == 0, "R10 released after NACK", b, 1);
    stop();
  endtask

  task automatic t_combined();
    bit a; logic [7:0] d1, d2;
    start(); send({7'h0A, 1'b0}, a); send(8'h18, a);
    start(); send({7'h0A, 1'b1}, a); recv(0, d1); recv(1, d2); stop();
    chk(d1 == 8'hB8, "R9 repeated-start read at pointer", d1, 8'hB8);
    chk(d2 == 8'h66, "R5 read wraps to 0x00", d2, 8'h66);
  endtask

  task automatic t_annul();
    bit a; logic [7:0] d;
    int c0 = wcount;
    start(); send({7'h0A, 1'b0}, a); send(8'h05, a);
    for (int i = 0; i < 4; i++) wbit(1);
    start(); stop();
    chk(wcount == c0, "R11 cut data byte not written", wcount - c0, 0);
    start(); send({7'h0A, 1'b1}, a); recv(1, d); stop();
    chk(d == 8'hA5, "R11 register kept", d, 8'hA5);
    start(); send({7'h0A, 1'b0}, a);
    for (int i = 0; i < 4; i++) wbit(0);
    stop();
    start(); send({7'h0A, 1'b1}, a); recv(1, d); stop();
    chk(d == 8'hA6, "R11 cut pointer byte leaves pointer", d, 8'hA6);
  endtask

  task automatic t_ptr_clamp();
    bit a; logic [7:0] d;
    start(); send({7'h0A, 1'b0}, a); send(8'h1F, a); stop();
    start(); send({7'h0A, 1'b1}, a); recv(1, d); stop();
    chk(d == 8'h66, "R3 pointer above 0x18 becomes 0x00", d, 8'h66);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_reset();
    t_first_read();
    t_addr_select();
    t_write();
    t_ro_wrap();
    t_resume_nack();
    t_combined();
    t_annul();
    t_ptr_clamp();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule